// File: doc/BRIEF.md
# Power-of-Two Attenuated Tone Injector

This block is a direct digital synthesizer that drives a stimulus tone into a live signed sample stream. A phase accumulator advances by a programmable frequency word on every clock. Its top bits address an in-line sine table, which yields a signed cosine (in-phase) and sine (quadrature) sample pair. That pair is presented unscaled as a reference for downstream correlators. A copy of the pair is attenuated by a power of two picked with a small intensity code. The attenuated in-phase sample is added, with saturation, to a through-path data stream.

With the enable low or under reset, the tone is silenced and the through path carries the source stream unchanged. Each rise of the enable restarts the tone at phase zero, so consecutive stimulus bursts are coherent. The frequency resolution is the clock rate divided by 2^W_PA. The table holds either one quarter of a period, mirrored by quadrant logic, or a full period. A build parameter picks which, and the outputs are the same in both cases.

Top module: `dds_exciter`

## Requirements
- R1: The first sample after the enable is seen high uses phase 0. Each later sample's phase is the previous phase plus `freq`, modulo 2^W_PA.
- R2: For a phase p, let k be the top LUT_AW bits of p, N = 2^LUT_AW and A = 2^(W_DDS-1)-1. Then `ref_i` = round(A·cos(2π(k+½)/N)) and `ref_q` = round(A·sin(2π(k+½)/N)), with halves rounded away from zero.
- R3: The sample for the enable sampled high at clock edge e appears on `ref_i`/`ref_q` after edge e+2. The following samples follow one per clock.
- R4: `exc_i`/`exc_q` equal the reference outputs of the previous cycle, arithmetically shifted right by 15−`intensity`. The `intensity` used is the value present at that edge. Codes of 15 or more give a shift of zero (full scale).
- R5: `src_out` equals `src_in` plus `exc_i`, both taken at the same edge, and is registered once. The sum is clamped to the signed W_SRC-bit range instead of wrapping.
- R6: When the enable is sampled low at edge e, the reference outputs are zero after edge e+2 and stay zero while it remains low. The next enable restarts the phase at 0.
- R7: A synchronous active-high `rst` clears the phase, all tone outputs and `src_out` to zero at the next edge.
- R8: While the excitation is zero, `src_out` is `src_in` delayed by one clock with no change of value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Excitation enable; a rising level restarts the phase |
| freq | input | W_PA | Phase increment per clock (unsigned, wraps) |
| intensity | input | W_INT | Attenuation code; shift = 15 − code, floored at 0 |
| src_in | input | W_SRC | Signed through-path input stream |
| ref_i | output | W_DDS | Unscaled signed cosine sample |
| ref_q | output | W_DDS | Unscaled signed sine sample |
| exc_i | output | W_DDS | Attenuated cosine sample |
| exc_q | output | W_DDS | Attenuated sine sample |
| src_out | output | W_SRC | Saturated sum of src_in and exc_i |

## Verification
The bench builds the block with an 8-bit tone, a 10-bit accumulator, a 64-entry period in the quarter-wave form, and an 8-bit through path. At these sizes a frequency word of 16 steps through every table entry within one burst. Word 1023 runs the tone backwards, and word 0 holds it at phase zero. Every intensity code from 0 to 15 is swept against each of these. Because the tone peak of 127 is as large as the through-path range, full-scale bursts against rail-valued source samples push the sum into both saturation limits. A reset placed in the middle of a burst and the restart on each enable edge are also covered.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Attenuation code at and above which no shift is applied.
  localparam int FULL_CODE = 15;

  // Right-shift amount for a given intensity code.
  function automatic int atten_shift(input int code);
    return (code >= FULL_CODE) ? 0 : (FULL_CODE - code);
  endfunction

  // Round to nearest, halves away from zero (symmetric for +/- values).
  function automatic int round_away(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    else          return -$rtoi(-x + 0.5);
  endfunction

  localparam real TWO_PI = 6.283185307179586;

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int W_PA   = 13,
  parameter int LUT_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [W_PA-1:0]   freq,
  output logic              vld_o,
  output logic [LUT_AW-1:0] addr_o
);

  logic [W_PA-1:0] acc;

  // vld_o marks that acc holds a live sample phase; the first live
  // sample after an idle period is always phase zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      acc   <= '0;
    end else begin
      vld_o <= en;
      acc   <= vld_o ? (acc + freq) : '0;
    end
  end

  assign addr_o = acc[W_PA-1 -: LUT_AW];

endmodule

// File: rtl/dds_sincos_rom.sv
module dds_sincos_rom #(
  parameter int W_DDS   = 12,
  parameter int LUT_AW  = 8,
  parameter bit QUARTER = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vld_i,
  input  logic [LUT_AW-1:0]       addr_i,
  output logic signed [W_DDS-1:0] cos_o,
  output logic signed [W_DDS-1:0] sin_o
);

  localparam int N   = 1 << LUT_AW;
  localparam int QN  = N / 4;
  localparam int QAW = LUT_AW - 2;
  localparam int TN  = QUARTER ? QN : N;
  localparam int TAW = QUARTER ? QAW : LUT_AW;
  localparam int AMP = (1 << (W_DDS - 1)) - 1;

  // Table of A*sin(2*pi*(j+0.5)/N); the half-step offset makes the
  // quadrant mirror exact, so the quarter and full forms agree.
  logic signed [W_DDS-1:0] tbl [TN];

  initial begin
    for (int j = 0; j < TN; j++) begin
      tbl[j] = W_DDS'(dds_pkg::round_away(
                 real'(AMP) * $sin(dds_pkg::TWO_PI * (real'(j) + 0.5) / real'(N))));
    end
  end

  // The cosine index is the sine index advanced by a quarter period.
  logic [LUT_AW-1:0] addr_s, addr_c;
  logic [TAW-1:0]    idx_s, idx_c;
  logic              neg_s, neg_c;

  assign addr_s = addr_i;
  assign addr_c = addr_i + LUT_AW'(QN);

  generate
    if (QUARTER) begin : g_quarter
      // Odd quadrants read the table backwards; upper half negates.
      assign idx_s = addr_s[LUT_AW-2] ? ~addr_s[QAW-1:0] : addr_s[QAW-1:0];
      assign idx_c = addr_c[LUT_AW-2] ? ~addr_c[QAW-1:0] : addr_c[QAW-1:0];
      assign neg_s = addr_s[LUT_AW-1];
      assign neg_c = addr_c[LUT_AW-1];
    end else begin : g_full
      assign idx_s = addr_s;
      assign idx_c = addr_c;
      assign neg_s = 1'b0;
      assign neg_c = 1'b0;
    end
  endgenerate

  // Stage 1: registered table reads (no reset, so block RAM maps).
  logic signed [W_DDS-1:0] mag_s, mag_c;
  logic                    neg_s_q, neg_c_q;
  logic                    vld_q;

  always_ff @(posedge clk) begin
    mag_s   <= tbl[idx_s];
    mag_c   <= tbl[idx_c];
    neg_s_q <= neg_s;
    neg_c_q <= neg_c;
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= vld_i;
  end

  // Stage 2: sign restore and silence gating.
  always_ff @(posedge clk) begin
    if (rst || !vld_q) begin
      cos_o <= '0;
      sin_o <= '0;
    end else begin
      cos_o <= neg_c_q ? -mag_c : mag_c;
      sin_o <= neg_s_q ? -mag_s : mag_s;
    end
  end

endmodule

// File: rtl/dds_atten.sv
module dds_atten #(
  parameter int W_DDS = 12,
  parameter int W_INT = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [W_INT-1:0]        code_i,
  input  logic signed [W_DDS-1:0] smp_i,
  output logic signed [W_DDS-1:0] smp_o
);

  logic [4:0] sh;

  always_comb sh = 5'(dds_pkg::atten_shift(int'(code_i)));

  always_ff @(posedge clk) begin
    if (rst) smp_o <= '0;
    else     smp_o <= smp_i >>> sh;
  end

endmodule

// File: rtl/dds_inject.sv
module dds_inject #(
  parameter int W_DDS = 12,
  parameter int W_SRC = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [W_SRC-1:0] src_i,
  input  logic signed [W_DDS-1:0] exc_i,
  output logic signed [W_SRC-1:0] src_o
);

  localparam int WSUM = ((W_SRC > W_DDS) ? W_SRC : W_DDS) + 1;
  localparam logic signed [WSUM-1:0] HI = WSUM'((1 << (W_SRC - 1)) - 1);
  localparam logic signed [WSUM-1:0] LO = ~HI;

  logic signed [WSUM-1:0] sum;

  always_comb sum = WSUM'(src_i) + WSUM'(exc_i);

  always_ff @(posedge clk) begin
    if (rst)            src_o <= '0;
    else if (sum > HI)  src_o <= HI[W_SRC-1:0];
    else if (sum < LO)  src_o <= LO[W_SRC-1:0];
    else                src_o <= sum[W_SRC-1:0];
  end

endmodule

// File: rtl/dds_exciter.sv
module dds_exciter #(
  parameter int W_DDS   = 12,
  parameter int W_PA    = W_DDS + 1,
  parameter int LUT_AW  = 8,
  parameter bit QUARTER = 1'b1,
  parameter int W_INT   = 4,
  parameter int W_SRC   = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [W_PA-1:0]         freq,
  input  logic [W_INT-1:0]        intensity,
  input  logic signed [W_SRC-1:0] src_in,
  output logic signed [W_DDS-1:0] ref_i,
  output logic signed [W_DDS-1:0] ref_q,
  output logic signed [W_DDS-1:0] exc_i,
  output logic signed [W_DDS-1:0] exc_q,
  output logic signed [W_SRC-1:0] src_out
);

  logic              ph_vld;
  logic [LUT_AW-1:0] ph_addr;

  dds_phase_acc #(.W_PA(W_PA), .LUT_AW(LUT_AW)) u_acc (
    .clk(clk), .rst(rst), .en(en), .freq(freq),
    .vld_o(ph_vld), .addr_o(ph_addr)
  );

  dds_sincos_rom #(.W_DDS(W_DDS), .LUT_AW(LUT_AW), .QUARTER(QUARTER)) u_rom (
    .clk(clk), .rst(rst), .vld_i(ph_vld), .addr_i(ph_addr),
    .cos_o(ref_i), .sin_o(ref_q)
  );

  dds_atten #(.W_DDS(W_DDS), .W_INT(W_INT)) u_att_i (
    .clk(clk), .rst(rst), .code_i(intensity), .smp_i(ref_i), .smp_o(exc_i)
  );

  dds_atten #(.W_DDS(W_DDS), .W_INT(W_INT)) u_att_q (
    .clk(clk), .rst(rst), .code_i(intensity), .smp_i(ref_q), .smp_o(exc_q)
  );

  dds_inject #(.W_DDS(W_DDS), .W_SRC(W_SRC)) u_inj (
    .clk(clk), .rst(rst), .src_i(src_in), .exc_i(exc_i), .src_o(src_out)
  );

endmodule

// File: rtl/dds_exciter_chk.sv
module dds_exciter_chk #(
  parameter int W_DDS = 12,
  parameter int W_PA  = W_DDS + 1,
  parameter int W_INT = 4,
  parameter int W_SRC = 14
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [W_PA-1:0]         freq,
  input logic [W_INT-1:0]        intensity,
  input logic signed [W_SRC-1:0] src_in,
  input logic signed [W_DDS-1:0] ref_i,
  input logic signed [W_DDS-1:0] ref_q,
  input logic signed [W_DDS-1:0] exc_i,
  input logic signed [W_DDS-1:0] exc_q,
  input logic signed [W_SRC-1:0] src_out
);

  localparam int AMP = (1 << (W_DDS - 1)) - 1;
  localparam logic signed [W_DDS-1:0] AMP_P = W_DDS'(AMP);
  localparam logic signed [W_DDS-1:0] AMP_N = W_DDS'(-AMP);

  a_r7_reset_quiet: assert property (@(posedge clk)
    rst |=> (ref_i == 0 && ref_q == 0 && exc_i == 0 && exc_q == 0 && src_out == 0));

  a_r6_disabled_zero: assert property (@(posedge clk) disable iff (rst)
    !en |=> ##2 (ref_i == 0 && ref_q == 0));

  a_r4_full_scale: assert property (@(posedge clk) disable iff (rst)
    (int'(intensity) >= 15) |=> (exc_i == $past(ref_i) && exc_q == $past(ref_q)));

  a_r5_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (exc_i >= 0) |=> (src_out >= $past(src_in)));

  a_r5_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
    (exc_i <= 0) |=> (src_out <= $past(src_in)));

  a_r2_amp_bound: assert property (@(posedge clk) disable iff (rst)
    (ref_i <= AMP_P && ref_i >= AMP_N && ref_q <= AMP_P && ref_q >= AMP_N));

  // freq is bound for completeness of the port view; no property uses it.
  logic unused_ok;
  assign unused_ok = ^freq;

endmodule

bind dds_exciter dds_exciter_chk #(
  .W_DDS(W_DDS), .W_PA(W_PA), .W_INT(W_INT), .W_SRC(W_SRC)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .freq(freq), .intensity(intensity),
  .src_in(src_in), .ref_i(ref_i), .ref_q(ref_q), .exc_i(exc_i),
  .exc_q(exc_q), .src_out(src_out)
);

// File: tb/sim_dds_exciter.sv
`timescale 1ns/1ps
module sim_dds_exciter;

  localparam int W_DDS  = 8;
  localparam int W_PA   = 10;
  localparam int LUT_AW = 6;
  localparam int W_INT  = 4;
  localparam int W_SRC  = 8;
  localparam int NTAB   = 1 << LUT_AW;
  localparam int AMP    = (1 << (W_DDS - 1)) - 1;
  localparam int SMAX   = (1 << (W_SRC - 1)) - 1;
  localparam int SMIN   = -(1 << (W_SRC - 1));
  localparam real TWOPI = 6.283185307179586;

  logic clk = 1'b0;
  logic rst, en;
  logic [W_PA-1:0] freq;
  logic [W_INT-1:0] intensity;
  logic signed [W_SRC-1:0] src_in;
  logic signed [W_DDS-1:0] ref_i, ref_q, exc_i, exc_q;
  logic signed [W_SRC-1:0] src_out;

  always #2.5 clk = ~clk;

  dds_exciter #(.W_DDS(W_DDS), .W_PA(W_PA), .LUT_AW(LUT_AW), .QUARTER(1'b1),
                .W_INT(W_INT), .W_SRC(W_SRC)) u0 (
    .clk(clk), .rst(rst), .en(en), .freq(freq), .intensity(intensity),
    .src_in(src_in), .ref_i(ref_i), .ref_q(ref_q), .exc_i(exc_i),
    .exc_q(exc_q), .src_out(src_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic int rnd(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction
  function automatic int tone_cos(input int k);
    return rnd(real'(AMP) * $cos(TWOPI * (real'(k) + 0.5) / real'(NTAB)));
  endfunction
  function automatic int tone_sin(input int k);
    return rnd(real'(AMP) * $sin(TWOPI * (real'(k) + 0.5) / real'(NTAB)));
  endfunction
  function automatic int attn(input int v, input int code);
    int sh;
    sh = (code >= 15) ? 0 : 15 - code;
    return v >>> sh;
  endfunction
  function automatic int clamp(input int v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model, advanced on each clock edge from the requirements.
  bit m_init = 0, m_rstd = 0, m_v0 = 0, m_v1 = 0, m_v2 = 0;
  int m_ph = 0, m_k1 = 0;
  int e_i = 0, e_q = 0, x_i = 0, x_q = 0, e_out = 0;

  always @(posedge clk) begin
    m_init <= 1'b1;
    m_rstd <= rst;
    if (rst) begin
      m_v0 <= 0; m_v1 <= 0; m_v2 <= 0; m_ph <= 0; m_k1 <= 0;
      e_i <= 0; e_q <= 0; x_i <= 0; x_q <= 0; e_out <= 0;
    end else begin
      m_v0  <= en;                                          // R1 phase restart
      m_ph  <= m_v0 ? (m_ph + int'(freq)) % (1 << W_PA) : 0;
      m_v1  <= m_v0;
      m_k1  <= m_ph >> (W_PA - LUT_AW);
      m_v2  <= m_v1;
      e_i   <= m_v1 ? tone_cos(m_k1) : 0;                   // R2, R3
      e_q   <= m_v1 ? tone_sin(m_k1) : 0;
      x_i   <= attn(e_i, int'(intensity));                  // R4
      x_q   <= attn(e_q, int'(intensity));
      e_out <= clamp(int'(src_in) + x_i);                   // R5
    end
  end

  always @(negedge clk) begin
    if (m_init && !done) begin
      string tr, tx, ts;
      tr = m_rstd ? "R7" : (m_v2 ? "R1 R2 R3" : "R6");
      tx = m_rstd ? "R7" : "R4";
      ts = m_rstd ? "R7" : ((x_i == 0) ? "R8" : "R5");
      chk(tr, "ref_i", int'(ref_i), e_i);
      chk(tr, "ref_q", int'(ref_q), e_q);
      chk(tx, "exc_i", int'(exc_i), x_i);
      chk(tx, "exc_q", int'(exc_q), x_q);
      chk(ts, "src_out", int'(src_out), e_out);
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int pattern(input int mode, input int c);
    case (mode)
      0: return ((c * 37) % 256) - 128;
      1: return (c % 2 == 0) ? SMAX : SMIN;
      default: return 0;
    endcase
  endfunction

  int fl [7] = '{16, 1, 7, 0, 500, 1023, 37};

  initial begin
    rst = 1'b1; en = 1'b0; freq = '0; intensity = '0; src_in = '0;
    repeat (4) @(negedge clk);
    // R7: reset state at the ports
    chk("R7", "ref_i after reset", int'(ref_i), 0);
    chk("R7", "src_out after reset", int'(src_out), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    for (int f = 0; f < 7; f++) begin
      for (int it = 0; it < 16; it++) begin
        freq = W_PA'(fl[f]);
        intensity = W_INT'(it);
        en = 1'b1;
        for (int c = 0; c < 70; c++) begin
          src_in = W_SRC'(pattern((it + f) % 3, c));
          @(negedge clk);
        end
        en = 1'b0;
        for (int c = 0; c < 6; c++) begin
          src_in = W_SRC'(pattern(0, c + it));   // R8 pass-through while idle
          @(negedge clk);
        end
      end
    end

    // R7: reset in the middle of a full-scale burst, enable held high
    freq = W_PA'(16); intensity = W_INT'(15); en = 1'b1; src_in = '0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R7", "ref_i mid-burst reset", int'(ref_i), 0);
    chk("R7", "exc_i mid-burst reset", int'(exc_i), 0);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    en = 1'b0;
    repeat (6) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule